// File: doc/BRIEF.md
# Split-Mode Timer/Event Counter with Capture

This block is a 16-bit counter that a 2-bit mode input can divide into two 8-bit halves. It has four shapes. The first is two independent prescaled 8-bit timers. The second is a prescaled 8-bit timer in the low half with an 8-bit event counter in the high half. The third is one prescaled 16-bit timer, and the fourth is one 16-bit event counter. Timer ticks come from a shared programmable prescaler. Event ticks come from rising edges of an asynchronous event input.

Every counter runs up to its match value and wraps to zero on the tick after that. At the wrap it raises a match flag for one cycle. Two asynchronous capture strobes, one for each half, latch the current count into the capture registers. In the 16-bit shapes, either strobe latches the whole 16-bit count. Changing the mode restarts both halves and the prescaler, so each shape starts from zero.

Top module: `ctc_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, both counts, both capture registers and both match flags read zero.
- R2: In a timer shape with reload value P, the prescaler yields one tick every P+1 clocks. After n clocks from reset release, a timer half that has not wrapped reads floor(n/(P+1)).
- R3: With mode 0, both halves count prescaled ticks on their own. Each half wraps from its own match value to 0 and raises its own flag (irq_lo or irq_hi) for exactly the cycle after that wrap.
- R4: With mode 1, the low half is a prescaled timer. The high half counts only rising edges of the event input.
- R5: With mode 2, {cnt_hi,cnt_lo} forms one 16-bit prescaled count that carries from low to high. It wraps after reaching {hi_match,lo_match} and pulses only irq_hi. irq_lo stays 0.
- R6: With mode 3, {cnt_hi,cnt_lo} counts event rising edges as one 16-bit value and wraps at {hi_match,lo_match}. The prescaler reload value has no effect on it.
- R7: The event and capture inputs pass through a two-flop synchroniser. Each rising edge counts once, for any high and low phases of at least one clock. A level held high counts only once.
- R8: In modes 0 and 1, a rising edge on cap_lo_in loads cnt_lo into cap_lo_q, and a rising edge on cap_hi_in loads cnt_hi into cap_hi_q. Neither strobe alters the other capture register.
- R9: In modes 2 and 3, a rising edge on either strobe loads the full 16-bit count into {cap_hi_q,cap_lo_q}.
- R10: A change of the mode input clears both counts and the prescaler at the next clock edge. The capture registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Shape select: 0 dual timer, 1 timer plus event counter, 2 wide timer, 3 wide event counter |
| pre_reload | input | PRE_W | Prescaler reload; a tick occurs every pre_reload+1 clocks |
| lo_match | input | HALF_W | Low-half match value (low byte of the 16-bit match) |
| hi_match | input | HALF_W | High-half match value (high byte of the 16-bit match) |
| evt_in | input | 1 | Asynchronous event input |
| cap_lo_in | input | 1 | Asynchronous low-half capture strobe |
| cap_hi_in | input | 1 | Asynchronous high-half capture strobe |
| cap_lo_q | output | HALF_W | Low capture register |
| cap_hi_q | output | HALF_W | High capture register |
| cnt_lo | output | HALF_W | Low-half count |
| cnt_hi | output | HALF_W | High-half count |
| irq_lo | output | 1 | Low-half match flag, one-cycle pulse |
| irq_hi | output | 1 | High-half (or 16-bit) match flag, one-cycle pulse |

## Verification
The counts are registered outputs, so a wrong prescaler phase, a missed carry or a bad wrap compare shows on cnt_lo or cnt_hi within one tick. A flag that is out of step shows in the same cycle as the wrap. The counts are swept every cycle against floor and modulo formulas, so an off-by-one in the reload or the match compare is caught at the first tick where it differs. A missing synchroniser stage, or a level detector in place of an edge detector, shows as a count too high or too low a few cycles after a pulse. A capture path wired to the wrong half shows in the capture registers after the next strobe.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [1:0] {
    MD_DUAL8    = 2'd0,
    MD_MIX      = 2'd1,
    MD_WIDE_TMR = 2'd2,
    MD_WIDE_EVT = 2'd3
  } tmode_e;

  function automatic logic is_wide(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = (pcnt >= reload);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/ctc_count_core.sv
module ctc_count_core
  import ctc_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [1:0]    mode,
  input  logic          tick_pre,
  input  logic          tick_evt,
  input  logic [HW-1:0] match_lo,
  input  logic [HW-1:0] match_hi,
  output logic [HW-1:0] cnt_lo,
  output logic [HW-1:0] cnt_hi,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int W2 = 2 * HW;

  logic          t_lo, t_hi;
  logic [W2-1:0] full, full_m;

  assign full   = {cnt_hi, cnt_lo};
  assign full_m = {match_hi, match_lo};

  always_comb begin
    case (tmode_e'(mode))
      MD_DUAL8:    begin t_lo = tick_pre; t_hi = tick_pre; end
      MD_MIX:      begin t_lo = tick_pre; t_hi = tick_evt; end
      MD_WIDE_TMR: begin t_lo = tick_pre; t_hi = tick_pre; end
      default:     begin t_lo = tick_evt; t_hi = tick_evt; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      if (is_wide(mode)) begin
        if (t_lo) begin
          if (full == full_m) begin
            {cnt_hi, cnt_lo} <= {W2{1'b0}};
            irq_hi <= 1'b1;
          end else begin
            {cnt_hi, cnt_lo} <= full + 1'b1;
          end
        end
      end else begin
        if (t_lo) begin
          if (cnt_lo == match_lo) begin
            cnt_lo <= '0;
            irq_lo <= 1'b1;
          end else begin
            cnt_lo <= cnt_lo + 1'b1;
          end
        end
        if (t_hi) begin
          if (cnt_hi == match_hi) begin
            cnt_hi <= '0;
            irq_hi <= 1'b1;
          end else begin
            cnt_hi <= cnt_hi + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import ctc_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [PRE_W-1:0]  pre_reload,
  input  logic [HALF_W-1:0] lo_match,
  input  logic [HALF_W-1:0] hi_match,
  input  logic              evt_in,
  input  logic              cap_lo_in,
  input  logic              cap_hi_in,
  output logic [HALF_W-1:0] cap_lo_q,
  output logic [HALF_W-1:0] cap_hi_q,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int NSYNC = 3;

  logic [1:0]       mode_q;
  logic             mode_chg;
  logic [NSYNC-1:0] rise;
  logic             pre_tick;

  always_ff @(posedge clk) mode_q <= mode;
  assign mode_chg = (mode != mode_q);

  ctc_edge_sync #(.N(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({cap_hi_in, cap_lo_in, evt_in}),
    .rise(rise)
  );

  ctc_prescaler #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (mode_chg),
    .reload(pre_reload),
    .tick  (pre_tick)
  );

  ctc_count_core #(.HW(HALF_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (mode_chg),
    .mode    (mode),
    .tick_pre(pre_tick),
    .tick_evt(rise[0]),
    .match_lo(lo_match),
    .match_hi(hi_match),
    .cnt_lo  (cnt_lo),
    .cnt_hi  (cnt_hi),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else if (is_wide(mode)) begin
      if (rise[1] || rise[2]) begin
        cap_lo_q <= cnt_lo;
        cap_hi_q <= cnt_hi;
      end
    end else begin
      if (rise[1]) cap_lo_q <= cnt_lo;
      if (rise[2]) cap_hi_q <= cnt_hi;
    end
  end
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [HALF_W-1:0] cap_lo_q,
  input logic [HALF_W-1:0] cap_hi_q,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              irq_lo,
  input logic              irq_hi
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (cnt_lo == '0 && cnt_hi == '0 && cap_lo_q == '0 && cap_hi_q == '0
               && !irq_lo && !irq_hi));

  a_r3_lo_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> cnt_lo == '0);

  a_r3_hi_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> cnt_hi == '0);

  a_r5_wide_no_lo_flag: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && $past(mode[1])) |-> !irq_lo);

  a_r10_mode_change_clear: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode) |=> (cnt_lo == '0 && cnt_hi == '0));
endmodule

bind ctc_timer ctc_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .cap_lo_q(cap_lo_q),
  .cap_hi_q(cap_hi_q),
  .cnt_lo  (cnt_lo),
  .cnt_hi  (cnt_hi),
  .irq_lo  (irq_lo),
  .irq_hi  (irq_hi)
);

// File: tb/ctc_timer_test.sv
module ctc_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [7:0] pre_reload = 8'd0;
  logic [7:0] lo_match = 8'hFF;
  logic [7:0] hi_match = 8'hFF;
  logic       evt_in = 1'b0;
  logic       cap_lo_in = 1'b0;
  logic       cap_hi_in = 1'b0;
  logic [7:0] cap_lo_q, cap_hi_q, cnt_lo, cnt_hi;
  logic       irq_lo, irq_hi;

  int total = 0;
  int fails = 0;
  int edges = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  ctc_timer uut (
    .clk(clk), .rst(rst), .mode(mode), .pre_reload(pre_reload),
    .lo_match(lo_match), .hi_match(hi_match), .evt_in(evt_in),
    .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
    .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q), .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic [7:0] p,
                         input logic [7:0] ml, input logic [7:0] mh);
    @(negedge clk);
    rst = 1'b1; mode = m; pre_reload = p; lo_match = ml; hi_match = mh;
    evt_in = 1'b0; cap_lo_in = 1'b0; cap_hi_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic evt_pulse(input int hw, input int lw);
    evt_in = 1'b1;
    repeat (hw) @(negedge clk);
    evt_in = 1'b0;
    repeat (lw) @(negedge clk);
  endtask

  task automatic cap_pulse(input bit hi);
    if (hi) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_hi_in = 1'b0; cap_lo_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int pulses;
    // R1: reset state
    restart(2'd0, 8'd0, 8'hFF, 8'hFF);
    chk("R1 cnt_lo", cnt_lo, 0);
    chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 caps", {cap_hi_q, cap_lo_q}, 0);
    chk("R1 flags", {irq_hi, irq_lo}, 0);

    // R2: prescaler sweep in mode 0
    for (int p = 0; p < 8; p++) begin
      restart(2'd0, 8'(p), 8'hFF, 8'hFF);
      repeat (37) @(negedge clk);
      chk("R2 lo prescaled", cnt_lo, edges / (p + 1));
      chk("R2 hi prescaled", cnt_hi, edges / (p + 1));
    end

    // R3: independent wrap and flags, mode 0
    restart(2'd0, 8'd0, 8'd4, 8'd6);
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      chk("R3 cnt_lo", cnt_lo, edges % 5);
      chk("R3 irq_lo", irq_lo, (edges > 0 && edges % 5 == 0) ? 1 : 0);
      chk("R3 cnt_hi", cnt_hi, edges % 7);
      chk("R3 irq_hi", irq_hi, (edges > 0 && edges % 7 == 0) ? 1 : 0);
    end

    // R5: 16-bit timer with carry and wrap at 0x0103
    restart(2'd2, 8'd0, 8'h03, 8'h01);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      chk("R5 count16", {cnt_hi, cnt_lo}, edges % 260);
      chk("R5 irq_hi", irq_hi, (edges > 0 && edges % 260 == 0) ? 1 : 0);
      chk("R5 irq_lo quiet", irq_lo, 0);
    end
    restart(2'd2, 8'd2, 8'hFF, 8'hFF);
    repeat (31) @(negedge clk);
    chk("R5 R2 prescaled16", {cnt_hi, cnt_lo}, edges / 3);

    // R4 / R7: mode 1, events of varied widths
    restart(2'd1, 8'd1, 8'hFF, 8'hFF);
    pulses = 0;
    for (int h = 1; h <= 3; h++)
      for (int l = 1; l <= 2; l++) begin
        evt_pulse(h, l);
        pulses++;
      end
    evt_pulse(12, 3);
    pulses++;
    repeat (4) @(negedge clk);
    chk("R4 R7 event count hi", cnt_hi, pulses);
    chk("R4 timer lo", cnt_lo, edges / 2);

    // R6: 16-bit event counter, prescaler ignored, wrap at 2
    restart(2'd3, 8'd0, 8'd2, 8'd0);
    repeat (20) @(negedge clk);
    chk("R6 no events no count", {cnt_hi, cnt_lo}, 0);
    evt_pulse(1, 1); evt_pulse(1, 1);
    repeat (4) @(negedge clk);
    chk("R6 two events", {cnt_hi, cnt_lo}, 2);
    evt_pulse(2, 2);
    repeat (4) @(negedge clk);
    chk("R6 wrap to zero", {cnt_hi, cnt_lo}, 0);

    // R9: 16-bit capture from either strobe
    restart(2'd3, 8'd5, 8'hFF, 8'hFF);
    for (int k = 0; k < 300; k++) evt_pulse(1, 1);
    repeat (4) @(negedge clk);
    chk("R6 300 events", {cnt_hi, cnt_lo}, 300);
    cap_pulse(1'b0);
    chk("R9 lo strobe full", {cap_hi_q, cap_lo_q}, 300);
    for (int k = 0; k < 5; k++) evt_pulse(1, 1);
    repeat (4) @(negedge clk);
    cap_pulse(1'b1);
    chk("R9 hi strobe full", {cap_hi_q, cap_lo_q}, 305);

    // R8: 8-bit captures in mode 1
    restart(2'd1, 8'd255, 8'hFF, 8'hFF);
    repeat (770) @(negedge clk);
    for (int k = 0; k < 5; k++) evt_pulse(2, 2);
    repeat (4) @(negedge clk);
    cap_pulse(1'b1);
    chk("R8 cap_hi", cap_hi_q, 5);
    chk("R8 cap_lo untouched", cap_lo_q, 0);
    cap_pulse(1'b0);
    chk("R8 cap_lo", cap_lo_q, edges / 256);
    chk("R8 cap_hi kept", cap_hi_q, 5);

    // R10: mode change clears counts, keeps captures
    mode = 2'd0;
    @(negedge clk);
    chk("R10 cnt_lo cleared", cnt_lo, 0);
    chk("R10 cnt_hi cleared", cnt_hi, 0);
    chk("R10 cap_lo kept", cap_lo_q, 3);
    chk("R10 cap_hi kept", cap_hi_q, 5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule